// File: doc/BRIEF.md
# CAN Bit Timing Logic

This block divides the system clock into time quanta and walks each CAN bit through a one-quantum synchronisation segment, a first phase segment and a second phase segment. It places the sample point between the two phase segments. There it captures the receive line and strobes the captured level to the bit stream processor. It also marks the start of every bit, which is the moment a transmitter drives its next bit. The processing time after the sample point is zero quanta, so the bit stream processor may present the next transmit bit immediately after the sample strobe.

The bit stream processor selects how the block follows edges on the receive line. It can ignore them, hard-synchronise to them, or resynchronise to them. A resynchronisation stretches the first phase segment or trims the second one, by at most the synchronisation jump width. While the node is bus-off, no synchronisation happens and the captured bit reads recessive.

Top module: `can_bit_timing`

## Requirements
- R1: `tq_tick_o` is high for one clock in every `brp_cfg_i`+1 clocks.
- R2: A bit lasts 1 + T1 + T2 quanta. T1 is `tseg1_cfg_i`+1, where a field of 0 also gives 2 quanta. T2 is `tseg2_cfg_i`+1. `tx_pt_o` pulses for one clock, one clock after the quantum tick that starts each bit.
- R3: `sample_pt_o` pulses 1 + T1 quanta after a bit start. `rx_bit_o` then holds the level that `rx_i` had on that tick, and it changes at no other time.
- R4: `sync_mode_i` encodes 00 as no synchronisation, 01 as hard synchronisation, 10 as resynchronisation and 11 as no synchronisation. In modes 00 and 11, edges on `rx_i` leave the bit timing unchanged.
- R5: In mode 01, a falling edge restarts the bit at the end of its synchronisation segment. A falling edge is `rx_i` low on a tick after being high on the previous tick. `tx_pt_o` pulses on the next clock, the sample point follows T1 quanta later, and the next bit starts T1 + T2 quanta later.
- R6: In mode 10, a falling edge seen e quanta after the synchronisation segment, while still in phase 1, delays the sample point by min(e, SJW) quanta. SJW is `sjw_cfg_i`+1.
- R7: In mode 10, a falling edge in phase 2 with r quanta of the bit still to run ends the bit min(r, SJW) quanta early. When r ≤ SJW, the next bit starts on that tick.
- R8: At most one resynchronisation is applied per bit.
- R9: While `bus_off_i` is high, no hard synchronisation or resynchronisation takes place, and the level captured at a sample point reads 1 (recessive).
- R10: During reset, `sample_pt_o` and `tx_pt_o` are 0 and `rx_bit_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| brp_cfg_i | input | BRP_W | Prescaler field; a quantum is this value + 1 clocks |
| tseg1_cfg_i | input | TS1_W | Phase 1 length minus one |
| tseg2_cfg_i | input | TS2_W | Phase 2 length minus one |
| sjw_cfg_i | input | SJW_W | Jump width minus one |
| rx_i | input | 1 | Receive line (1 recessive) |
| sync_mode_i | input | 2 | Synchronisation mode from the bit stream processor |
| bus_off_i | input | 1 | Node is bus-off |
| tq_tick_o | output | 1 | Quantum tick |
| sample_pt_o | output | 1 | Sample point strobe |
| rx_bit_o | output | 1 | Receive level captured at the sample point |
| tx_pt_o | output | 1 | Bit start strobe, where the next transmit bit is driven |

## Verification
A table of prescaler and segment settings, including the smallest bit, the largest bit and the clamped phase-1 field, shows that quantum and segment lengths combine correctly. On a fixed 6+3 quantum bit, a single falling edge is placed at chosen quanta under each mode. Edges early and late in phase 1 separate the uncapped case from the jump-width cap. Edges in phase 2 show whether the bit is cut at once or trimmed by exactly the jump width, and a second edge in the same bit shows whether the one-per-bit limit holds. Repeating the same edge with bus-off set, or with a mode that ignores edges, must reproduce the untouched timing, and bus-off must also force the captured level.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  localparam int QW = 8;
  typedef logic [QW-1:0] qcnt_t;

  localparam qcnt_t Q_ONE = qcnt_t'(1);
  localparam qcnt_t Q_TWO = qcnt_t'(2);

  typedef enum logic [1:0] {
    SM_NONE   = 2'b00,
    SM_HARD   = 2'b01,
    SM_RESYNC = 2'b10,
    SM_RSVD   = 2'b11
  } sync_mode_e;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'b00,
    SEG_PH1  = 2'b01,
    SEG_PH2  = 2'b10
  } seg_e;

  function automatic qcnt_t q_min(input qcnt_t a, input qcnt_t b);
    return (a < b) ? a : b;
  endfunction

  // phase 1 never shorter than two quanta
  function automatic qcnt_t ph1_quanta(input qcnt_t field);
    return (field == '0) ? Q_TWO : field + Q_ONE;
  endfunction

  function automatic qcnt_t plus_one(input qcnt_t field);
    return field + Q_ONE;
  endfunction

  // quanta still to run in phase 2 after the current one
  function automatic qcnt_t ph2_left(input qcnt_t len, input qcnt_t cnt,
                                     input qcnt_t cut);
    qcnt_t used;
    used = cnt + Q_ONE + cut;
    return (len > used) ? len - used : '0;
  endfunction

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BRP_W-1:0] brp_i,
  output logic             tick_o
);

  logic [BRP_W-1:0] div_q;

  assign tick_o = (div_q >= brp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (tick_o) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic bus_off_i,
  output logic fall_o
);

  logic last_q;

  assign fall_o = tick_i & last_q & ~rx_i & ~bus_off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b1;
    end else if (tick_i) begin
      last_q <= rx_i;
    end
  end

endmodule

// File: rtl/can_bt_segfsm.sv
module can_bt_segfsm
  import can_bt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       fall_i,
  input  sync_mode_e mode_i,
  input  qcnt_t      t1_i,
  input  qcnt_t      t2_i,
  input  qcnt_t      sjw_i,
  output logic       sample_o,
  output logic       start_o
);

  seg_e  seg_q, seg_d;
  qcnt_t cnt_q, cnt_d;
  qcnt_t ext_q, ext_d;
  qcnt_t cut_q, cut_d;
  logic  used_q, used_d;

  logic  hard_go, resync_go;
  qcnt_t late_step, early_step, left;

  assign hard_go    = fall_i & (mode_i == SM_HARD);
  assign resync_go  = fall_i & (mode_i == SM_RESYNC) & ~used_q;
  assign late_step  = q_min(cnt_q + Q_ONE, sjw_i);
  assign left       = ph2_left(t2_i, cnt_q, cut_q);
  assign early_step = q_min(left, sjw_i);

  always_comb begin
    seg_d    = seg_q;
    cnt_d    = cnt_q;
    ext_d    = ext_q;
    cut_d    = cut_q;
    used_d   = used_q;
    sample_o = 1'b0;
    start_o  = 1'b0;
    if (tick_i) begin
      if (hard_go) begin
        seg_d   = SEG_PH1;
        cnt_d   = '0;
        ext_d   = '0;
        cut_d   = '0;
        used_d  = 1'b1;
        start_o = 1'b1;
      end else begin
        unique case (seg_q)
          SEG_PH1: begin
            if (resync_go) begin
              ext_d  = ext_q + late_step;
              used_d = 1'b1;
            end
            if (cnt_q + Q_ONE >= t1_i + ext_d) begin
              sample_o = 1'b1;
              seg_d    = SEG_PH2;
              cnt_d    = '0;
            end else begin
              cnt_d = cnt_q + Q_ONE;
            end
          end
          SEG_PH2: begin
            if (resync_go) begin
              cut_d  = cut_q + early_step;
              used_d = 1'b1;
            end
            if ((cnt_q + Q_ONE + cut_d) >= t2_i) begin
              seg_d   = SEG_SYNC;
              cnt_d   = '0;
              ext_d   = '0;
              cut_d   = '0;
              used_d  = 1'b0;
              start_o = 1'b1;
            end else begin
              cnt_d = cnt_q + Q_ONE;
            end
          end
          default: begin
            if (resync_go) used_d = 1'b1;
            seg_d = SEG_PH1;
            cnt_d = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_SYNC;
      cnt_q  <= '0;
      ext_q  <= '0;
      cut_q  <= '0;
      used_q <= 1'b0;
    end else begin
      seg_q  <= seg_d;
      cnt_q  <= cnt_d;
      ext_q  <= ext_d;
      cut_q  <= cut_d;
      used_q <= used_d;
    end
  end

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import can_bt_pkg::*;
#(
  parameter int BRP_W = 6,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BRP_W-1:0] brp_cfg_i,
  input  logic [TS1_W-1:0] tseg1_cfg_i,
  input  logic [TS2_W-1:0] tseg2_cfg_i,
  input  logic [SJW_W-1:0] sjw_cfg_i,
  input  logic             rx_i,
  input  logic [1:0]       sync_mode_i,
  input  logic             bus_off_i,
  output logic             tq_tick_o,
  output logic             sample_pt_o,
  output logic             rx_bit_o,
  output logic             tx_pt_o
);

  localparam int MAX_BIT_Q = 1 + (1 << TS1_W) + (1 << TS2_W);

  initial begin
    if (MAX_BIT_Q + (1 << SJW_W) >= (1 << QW)) $error("segment fields too wide");
  end

  logic  tick, fall_evt, sample_evt, start_evt;
  qcnt_t t1_len, t2_len, sjw_len;

  assign t1_len  = ph1_quanta(qcnt_t'(tseg1_cfg_i));
  assign t2_len  = plus_one(qcnt_t'(tseg2_cfg_i));
  assign sjw_len = plus_one(qcnt_t'(sjw_cfg_i));

  can_bt_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .brp_i (brp_cfg_i),
    .tick_o(tick)
  );

  can_bt_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .rx_i     (rx_i),
    .bus_off_i(bus_off_i),
    .fall_o   (fall_evt)
  );

  can_bt_segfsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .fall_i  (fall_evt),
    .mode_i  (sync_mode_e'(sync_mode_i)),
    .t1_i    (t1_len),
    .t2_i    (t2_len),
    .sjw_i   (sjw_len),
    .sample_o(sample_evt),
    .start_o (start_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_pt_o <= 1'b0;
      tx_pt_o     <= 1'b0;
      rx_bit_o    <= 1'b1;
    end else begin
      sample_pt_o <= sample_evt;
      tx_pt_o     <= start_evt;
      if (sample_evt) rx_bit_o <= rx_i | bus_off_i;
    end
  end

  assign tq_tick_o = tick;

endmodule

// File: rtl/can_bit_timing_chk.sv
module can_bit_timing_chk #(
  parameter int BRP_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [BRP_W-1:0] brp_cfg_i,
  input logic [1:0]       sync_mode_i,
  input logic             bus_off_i,
  input logic             tq_tick_i,
  input logic             fall_evt_i,
  input logic             sample_pt_i,
  input logic             tx_pt_i,
  input logic             rx_bit_i
);

  logic [BRP_W:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= '0;
    else if (tq_tick_i) gap_q <= '0;
    else gap_q <= gap_q + 1'b1;
  end

  a_r1_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tq_tick_i |-> (gap_q == {1'b0, brp_cfg_i}));

  a_r2_strobe_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_pt_i || tx_pt_i) |-> $past(tq_tick_i));

  a_r3_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_pt_i && tx_pt_i));

  a_r3_bit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_pt_i |-> $stable(rx_bit_i));

  a_r5_hard_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_evt_i && sync_mode_i == 2'b01) |=> tx_pt_i);

  a_r9_busoff_recessive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_pt_i && $past(bus_off_i)) |-> rx_bit_i);

endmodule

bind can_bit_timing can_bit_timing_chk #(.BRP_W(BRP_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .brp_cfg_i  (brp_cfg_i),
  .sync_mode_i(sync_mode_i),
  .bus_off_i  (bus_off_i),
  .tq_tick_i  (tq_tick_o),
  .fall_evt_i (fall_evt),
  .sample_pt_i(sample_pt_o),
  .tx_pt_i    (tx_pt_o),
  .rx_bit_i   (rx_bit_o)
);

// File: tb/can_bit_timing_tb.sv
module can_bit_timing_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] brp = '0;
  logic [3:0] ts1 = '0;
  logic [2:0] ts2 = '0;
  logic [1:0] sjw = '0;
  logic       rx = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       boff = 1'b0;
  logic       tq_tick, sample_pt, rx_bit, tx_pt;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  can_bit_timing dut_i (
    .clk_i(clk), .rst_ni(rst_n), .brp_cfg_i(brp), .tseg1_cfg_i(ts1),
    .tseg2_cfg_i(ts2), .sjw_cfg_i(sjw), .rx_i(rx), .sync_mode_i(mode),
    .bus_off_i(boff), .tq_tick_o(tq_tick), .sample_pt_o(sample_pt),
    .rx_bit_o(rx_bit), .tx_pt_o(tx_pt)
  );

  // brp, tseg1, tseg2, sjw, clocks per bit, clocks from bit start to sample
  localparam int VEC [6][6] = '{
    '{0, 2, 1, 0,   6,  4},
    '{1, 5, 2, 1,  20, 14},
    '{3, 15, 7, 3, 100, 68},
    '{0, 1, 0, 0,   4,  3},
    '{0, 0, 0, 0,   4,  3},
    '{2, 7, 4, 2,  42, 27}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(input int b, input int t1, input int t2, input int j,
                         input logic [1:0] m, input logic bo);
    int seen;
    @(negedge clk);
    rst_n = 1'b0;
    brp = 6'(b); ts1 = 4'(t1); ts2 = 3'(t2); sjw = 2'(j);
    mode = m; boff = bo; rx = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    seen = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (tx_pt) begin seen = 1; break; end
    end
    check(seen == 1, "R2 first bit start", seen, 1);
  endtask

  // counts clocks from the current bit start; rx is changed at chosen counts
  task automatic run_bit(input int d1, input int r1, input int d2,
                         output int samp_n, output int samp_v, output int tx_n);
    samp_n = -1; samp_v = -1; tx_n = -1;
    for (int n = 1; n <= 300; n++) begin
      @(negedge clk);
      if (sample_pt && samp_n < 0) begin samp_n = n; samp_v = int'(rx_bit); end
      if (tx_pt) begin tx_n = n; break; end
      if (n == d1) rx = 1'b0;
      if (n == r1) rx = 1'b1;
      if (n == d2) rx = 1'b0;
    end
  endtask

  initial begin
    int sn, sv, tn, ticks;
    // R10 reset values
    repeat (2) @(negedge clk);
    check(sample_pt == 1'b0, "R10 sample strobe in reset", int'(sample_pt), 0);
    check(tx_pt == 1'b0, "R10 bit start in reset", int'(tx_pt), 0);
    check(rx_bit == 1'b1, "R10 captured bit in reset", int'(rx_bit), 1);

    // R2 / R3 timing table
    for (int v = 0; v < 6; v++) begin
      restart(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 2'b00, 1'b0);
      run_bit(-1, -1, -1, sn, sv, tn);
      check(sn == VEC[v][5], "R3 sample offset", sn, VEC[v][5]);
      check(tn == VEC[v][4], "R2 bit length", tn, VEC[v][4]);
      check(sv == 1, "R3 captured recessive", sv, 1);
    end

    // R1 tick spacing
    restart(3, 2, 1, 0, 2'b00, 1'b0);
    ticks = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tq_tick) ticks++;
    end
    check(ticks == 10, "R1 ticks per 40 clocks", ticks, 10);

    // the remaining cases use one clock per quantum, T1=6, T2=3
    restart(0, 5, 2, 1, 2'b00, 1'b0);
    run_bit(1, -1, -1, sn, sv, tn);
    check(sn == 7, "R4 mode 00 sample", sn, 7);
    check(sv == 0, "R3 captured dominant", sv, 0);
    check(tn == 10, "R4 mode 00 bit length", tn, 10);

    restart(0, 5, 2, 1, 2'b11, 1'b0);
    run_bit(1, -1, -1, sn, sv, tn);
    check(sn == 7, "R4 mode 11 sample", sn, 7);
    check(tn == 10, "R4 mode 11 bit length", tn, 10);

    restart(0, 5, 2, 1, 2'b10, 1'b0);
    run_bit(1, -1, -1, sn, sv, tn);
    check(sn == 8, "R6 late edge e=1", sn, 8);
    check(tn == 11, "R6 stretched bit", tn, 11);

    restart(0, 5, 2, 1, 2'b10, 1'b0);
    run_bit(4, -1, -1, sn, sv, tn);
    check(sn == 9, "R6 capped at SJW", sn, 9);
    check(tn == 12, "R6 capped bit", tn, 12);

    restart(0, 5, 2, 1, 2'b10, 1'b0);
    run_bit(7, -1, -1, sn, sv, tn);
    check(sn == 7, "R7 sample before edge", sn, 7);
    check(tn == 8, "R7 bit ends at once", tn, 8);

    restart(0, 5, 2, 0, 2'b10, 1'b0);
    run_bit(7, -1, -1, sn, sv, tn);
    check(tn == 9, "R7 trimmed by SJW", tn, 9);

    restart(0, 5, 2, 1, 2'b10, 1'b0);
    run_bit(1, 2, 3, sn, sv, tn);
    check(sn == 8, "R8 second edge ignored", sn, 8);
    check(tn == 11, "R8 bit length", tn, 11);

    restart(0, 5, 2, 1, 2'b10, 1'b1);
    run_bit(1, -1, -1, sn, sv, tn);
    check(sn == 7, "R9 no resync when bus-off", sn, 7);
    check(sv == 1, "R9 captured reads recessive", sv, 1);

    restart(0, 5, 2, 1, 2'b01, 1'b1);
    run_bit(3, -1, -1, sn, sv, tn);
    check(tn == 10, "R9 no hard sync when bus-off", tn, 10);

    restart(0, 5, 2, 1, 2'b01, 1'b0);
    run_bit(3, -1, -1, sn, sv, tn);
    check(tn == 4, "R5 hard sync restart", tn, 4);
    check(sn == -1, "R5 no sample before restart", sn, -1);
    run_bit(-1, -1, -1, sn, sv, tn);
    check(sn == 6, "R5 sample after hard sync", sn, 6);
    check(tn == 9, "R5 next bit after hard sync", tn, 9);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule